// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is a reconfigurable AND-OR plane. Sixteen logic inputs each enter the array twice, once as themselves and once inverted, which gives 32 columns. Sixty-four product terms are formed from those columns under control of a configuration vector. The terms are split into eight groups of eight, and every group is ORed into one output. The raw product terms are also brought out, and the first term of every group is tapped separately so that a downstream output cell can use it as an enable.

Each product term has one disable bit of its own. An erased configuration (all ones) therefore leaves every column open and every term forced low. The configuration can pass through a register that captures the ports on a load strobe. This path is selected by a parameter and is on by default. With it on, the array sees a steady configuration while the ports change. The path from the inputs to the outputs has no register in it.

Top module: `sop_array`

## Requirements
- R1: Column 2*i carries input bit i and column 2*i+1 carries its inverse, for i in 0..15.
- R2: Configuration bit index t*32+c ties column c to term t when it is 0 and leaves it open when it is 1. A term is the AND of its tied columns.
- R3: A term with no tied columns and a clear disable bit evaluates to 1.
- R4: A term whose disable bit (cfg_kill[t]) is 1 evaluates to 0, whatever its row and the inputs are.
- R5: A term that ties both the true and the inverted column of the same input evaluates to 0 for every input value.
- R6: Output sop_out[g] is the OR of terms 8*g through 8*g+7.
- R7: oe_term[g] equals term 8*g, the first term of group g.
- R8: From reset until the first load, the active configuration is all ones. Every term and output is then 0 for any input.
- R9: A configuration on the ports becomes active after a rising clock edge that samples cfg_load high. Port changes without that strobe have no effect on the outputs.
- R10: Terms and outputs follow din within the same cycle, with no register on that path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Synchronous active-low reset, restores the erased configuration |
| cfg_load | input | 1 | Strobe that captures cfg_and and cfg_kill |
| cfg_and | input | 2048 | Connection bits, bit t*32+c for term t and column c, 0 = tied |
| cfg_kill | input | 64 | Per-term disable bits, 1 forces the term to 0 |
| din | input | 16 | Logic inputs |
| sop_out | output | 8 | One sum-of-products result per group |
| pterm | output | 64 | All product terms |
| oe_term | output | 8 | First term of each group |

## Verification
A configuration becomes active one clock edge after cfg_load is sampled high. The bench drives the strobe on a falling edge, drops it on the next falling edge, and only then applies inputs. The outputs depend on din with no clock in between. Each input pattern is therefore driven on a falling edge and sampled two time units later, well before the next rising edge. The no-effect check changes the configuration ports without a strobe. It waits two full cycles and then expects the outputs of the previously loaded configuration.

// File: rtl/sop_pkg.sv
// Package: types and helpers shared by the sum-of-products array.
// Assumes the column order true-then-inverse for each input.
package sop_pkg;

    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_COMP = 1'b1
    } pol_e;

    // Column position of one polarity of one input in the array.
    function automatic int unsigned col_of(input int unsigned inp, input pol_e pol);
        return (inp << 1) | {31'd0, pol};
    endfunction

endpackage

// File: rtl/sop_input_buf.sv
// Input buffer: presents every input as a true and an inverted column.
// Assumes the column order given by sop_pkg::col_of.
module sop_input_buf
    import sop_pkg::*;
#(
    parameter int N_IN = 16,
    localparam int N_COL = 2 * N_IN
) (
    input  logic [N_IN-1:0]  din,
    output logic [N_COL-1:0] cols
);

    for (genvar i = 0; i < N_IN; i++) begin : g_col
        localparam int unsigned TI = col_of(i, POL_TRUE);
        localparam int unsigned CI = col_of(i, POL_COMP);
        // Drive both polarities of input i onto their columns.
        assign cols[TI] = din[i];
        assign cols[CI] = ~din[i];
    end

endmodule

// File: rtl/sop_cfg_store.sv
// Configuration store: either registers the configuration on a load strobe
// or passes it straight through. The choice is made by REG.
// Assumes synchronous active-low reset to the erased (all ones) pattern.
module sop_cfg_store #(
    parameter int N_TERM = 64,
    parameter int N_COL  = 32,
    parameter bit REG    = 1'b1,
    localparam int CFG_W = N_TERM * N_COL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CFG_W-1:0]  and_in,
    input  logic [N_TERM-1:0] kill_in,
    output logic [CFG_W-1:0]  and_out,
    output logic [N_TERM-1:0] kill_out
);

    if (REG) begin : g_reg
        // Capture the ports on a load, erase on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                and_out  <= '1;
                kill_out <= '1;
            end else if (load) begin
                and_out  <= and_in;
                kill_out <= kill_in;
            end
        end
    end else begin : g_wire
        // Feed the ports straight through to the array.
        assign and_out  = and_in;
        assign kill_out = kill_in;
    end

endmodule

// File: rtl/sop_and_plane.sv
// AND plane: each row ANDs the columns whose bit is 0 and is forced
// low by its disable bit. Assumes row-major bits, row t at t*N_COL.
module sop_and_plane #(
    parameter int N_COL  = 32,
    parameter int N_TERM = 64,
    localparam int CFG_W = N_TERM * N_COL
) (
    input  logic [N_COL-1:0]  cols,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [N_TERM-1:0] kill,
    output logic [N_TERM-1:0] terms
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_row
        logic [N_COL-1:0] row;
        // An open bit (1) masks its column to 1 inside the AND.
        assign row      = cfg[t*N_COL +: N_COL];
        assign terms[t] = ~kill[t] & (&(cols | row));
    end

endmodule

// File: rtl/sop_or_plane.sv
// OR plane: ORs each group of TPG consecutive terms and taps the first
// term of each group. Assumes groups are contiguous term ranges.
module sop_or_plane #(
    parameter int N_GRP = 8,
    parameter int TPG   = 8,
    localparam int N_TERM = N_GRP * TPG
) (
    input  logic [N_TERM-1:0] terms,
    output logic [N_GRP-1:0]  sop,
    output logic [N_GRP-1:0]  oe
);

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        // Fixed OR over the group and tap of its first term.
        assign sop[g] = |terms[g*TPG +: TPG];
        assign oe[g]  = terms[g*TPG];
    end

endmodule

// File: rtl/sop_array.sv
// Programmable sum-of-products array top: input buffer, configuration
// store, AND plane and OR plane. Combinational from din to the outputs.
// Assumes rst_n is synchronous and active low.
module sop_array #(
    parameter int N_IN    = 16,
    parameter int N_GRP   = 8,
    parameter int TPG     = 8,
    parameter bit CFG_REG = 1'b1,
    localparam int N_COL  = 2 * N_IN,
    localparam int N_TERM = N_GRP * TPG,
    localparam int CFG_W  = N_TERM * N_COL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [CFG_W-1:0]  cfg_and,
    input  logic [N_TERM-1:0] cfg_kill,
    input  logic [N_IN-1:0]   din,
    output logic [N_GRP-1:0]  sop_out,
    output logic [N_TERM-1:0] pterm,
    output logic [N_GRP-1:0]  oe_term
);

    logic [N_COL-1:0]  cols;
    logic [CFG_W-1:0]  act_and;
    logic [N_TERM-1:0] act_kill;

    sop_input_buf #(.N_IN(N_IN)) u_buf (
        .din  (din),
        .cols (cols)
    );

    sop_cfg_store #(.N_TERM(N_TERM), .N_COL(N_COL), .REG(CFG_REG)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .and_in   (cfg_and),
        .kill_in  (cfg_kill),
        .and_out  (act_and),
        .kill_out (act_kill)
    );

    sop_and_plane #(.N_COL(N_COL), .N_TERM(N_TERM)) u_and (
        .cols  (cols),
        .cfg   (act_and),
        .kill  (act_kill),
        .terms (pterm)
    );

    sop_or_plane #(.N_GRP(N_GRP), .TPG(TPG)) u_or (
        .terms (pterm),
        .sop   (sop_out),
        .oe    (oe_term)
    );

endmodule

// File: rtl/sop_array_chk.sv
// Checker for sop_array: relates the configuration store, the planes and
// the ports over time. Bound to every sop_array instance below.
module sop_array_chk #(
    parameter int N_GRP   = 8,
    parameter int TPG     = 8,
    parameter int N_COL   = 32,
    parameter bit CFG_REG = 1'b1,
    localparam int N_TERM = N_GRP * TPG,
    localparam int CFG_W  = N_TERM * N_COL
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic [CFG_W-1:0]  cfg_and,
    input logic [N_TERM-1:0] cfg_kill,
    input logic [CFG_W-1:0]  act_and,
    input logic [N_TERM-1:0] act_kill,
    input logic [N_TERM-1:0] pterm,
    input logic [N_GRP-1:0]  sop_out,
    input logic [N_GRP-1:0]  oe_term
);

    AST_KILLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pterm & act_kill) == '0); // R4

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        AST_OE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
            oe_term[g] == pterm[g*TPG]); // R7
        AST_GROUP_OR: assert property (@(posedge clk) disable iff (!rst_n)
            sop_out[g] == (pterm[g*TPG +: TPG] != '0)); // R6
    end

    if (CFG_REG) begin : g_reg
        AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_load |=> (act_and == $past(cfg_and)) && (act_kill == $past(cfg_kill))); // R9
        AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_load |=> $stable(act_and) && $stable(act_kill)); // R9
    end

endmodule

bind sop_array sop_array_chk #(
    .N_GRP   (N_GRP),
    .TPG     (TPG),
    .N_COL   (N_COL),
    .CFG_REG (CFG_REG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_and  (cfg_and),
    .cfg_kill (cfg_kill),
    .act_and  (act_and),
    .act_kill (act_kill),
    .pterm    (pterm),
    .sop_out  (sop_out),
    .oe_term  (oe_term)
);

// File: tb/sop_array_tb_top.sv
// Bench for sop_array: directed corner cases plus seeded random
// configurations, checked against bench-side model functions.
module sop_array_tb_top;

    localparam int N_IN   = 16;
    localparam int N_GRP  = 8;
    localparam int TPG    = 8;
    localparam int N_COL  = 2 * N_IN;
    localparam int N_TERM = N_GRP * TPG;
    localparam int CFG_W  = N_TERM * N_COL;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic [CFG_W-1:0]  cfg_and = '1;
    logic [N_TERM-1:0] cfg_kill = '1;
    logic [N_IN-1:0]   din = '0;
    logic [N_GRP-1:0]  sop_out;
    logic [N_TERM-1:0] pterm;
    logic [N_GRP-1:0]  oe_term;

    int checks = 0;
    int errors = 0;

    logic [CFG_W-1:0]  m_and;
    logic [N_TERM-1:0] m_kill;

    always #10 clk = ~clk;

    sop_array dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_and  (cfg_and),
        .cfg_kill (cfg_kill),
        .din      (din),
        .sop_out  (sop_out),
        .pterm    (pterm),
        .oe_term  (oe_term)
    );

    function automatic logic [N_TERM-1:0] exp_terms(input logic [CFG_W-1:0] a,
                                                    input logic [N_TERM-1:0] k,
                                                    input logic [N_IN-1:0] d);
        logic [N_TERM-1:0] r;
        for (int t = 0; t < N_TERM; t++) begin
            r[t] = !k[t];
            for (int i = 0; i < N_IN; i++) begin
                if (!a[t*N_COL + 2*i] && !d[i]) r[t] = 1'b0;
                if (!a[t*N_COL + 2*i + 1] && d[i]) r[t] = 1'b0;
            end
        end
        return r;
    endfunction

    function automatic logic [N_GRP-1:0] exp_sop(input logic [N_TERM-1:0] tr);
        logic [N_GRP-1:0] r;
        r = '0;
        for (int t = 0; t < N_TERM; t++) if (tr[t]) r[t/TPG] = 1'b1;
        return r;
    endfunction

    function automatic logic [N_GRP-1:0] exp_oe(input logic [N_TERM-1:0] tr);
        logic [N_GRP-1:0] r;
        for (int g = 0; g < N_GRP; g++) r[g] = tr[g*TPG];
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [N_TERM-1:0] act, input logic [N_TERM-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply one input pattern and compare all outputs in the same cycle.
    task automatic apply(input string req, input logic [N_IN-1:0] d);
        logic [N_TERM-1:0] et;
        @(negedge clk);
        din = d;
        #2;
        et = exp_terms(m_and, m_kill, d);
        chk(req, "pterm", pterm, et);
        chk(req, "sop_out", {56'd0, sop_out}, {56'd0, exp_sop(et)});
        chk(req, "oe_term", {56'd0, oe_term}, {56'd0, exp_oe(et)});
    endtask

    task automatic load(input logic [CFG_W-1:0] a, input logic [N_TERM-1:0] k);
        @(negedge clk);
        cfg_and  = a;
        cfg_kill = k;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        m_and  = a;
        m_kill = k;
    endtask

    initial begin : watchdog
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [CFG_W-1:0]  a;
        logic [N_TERM-1:0] k;
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        m_and  = '1;
        m_kill = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: erased after reset, all outputs low whatever the inputs.
        apply("R8", 16'h0000);
        apply("R8", 16'hFFFF);
        apply("R8", 16'hA5C3);

        // R3: every row open, no term disabled, so every term is 1.
        load('1, '0);
        apply("R3", 16'h1234);
        chk("R3", "all terms high", pterm, '1);

        // R4: disable every other term on an all-open plane.
        load('1, {32{2'b01}});
        apply("R4", 16'hBEEF);
        chk("R4", "odd terms only", pterm, {32{2'b10}});

        // R5: term 3 ties both polarities of input 3; term 12 both of input 0.
        a = '1;
        a[3*N_COL + 6]  = 1'b0;
        a[3*N_COL + 7]  = 1'b0;
        a[12*N_COL + 0] = 1'b0;
        a[12*N_COL + 1] = 1'b0;
        load(a, '0);
        for (int v = 0; v < 4; v++) begin
            apply("R5", 16'(v * 16'h1111));
            chk("R5", "contradictory terms", {62'd0, pterm[12], pterm[3]}, 64'd0);
        end

        // R1 R2: term 0 ties true of input 5, term 9 ties inverse of input 5.
        a = '1;
        a[0*N_COL + 10] = 1'b0;
        a[9*N_COL + 11] = 1'b0;
        k = '1;
        k[0] = 1'b0;
        k[9] = 1'b0;
        load(a, k);
        apply("R1", 16'h0020);
        chk("R2", "input5 high", {62'd0, pterm[9], pterm[0]}, 64'd1);
        apply("R1", 16'hFFDF);
        chk("R2", "input5 low", {62'd0, pterm[9], pterm[0]}, 64'd2);

        // R9: change ports without the strobe, outputs must keep old config.
        @(negedge clk);
        cfg_and  = '1;
        cfg_kill = '0;
        repeat (2) @(negedge clk);
        apply("R9", 16'hFFDF);
        chk("R9", "no strobe no change", pterm, 64'h200);
        load('1, '0);
        apply("R9", 16'hFFDF);
        chk("R9", "strobe applies", pterm, '1);

        // R6 R7 R10: random sparse configurations and random inputs.
        for (int n = 0; n < 20; n++) begin
            for (int b = 0; b < CFG_W; b++) a[b] = ($urandom_range(0, 15) != 0);
            for (int t = 0; t < N_TERM; t++) k[t] = ($urandom_range(0, 7) == 0);
            load(a, k);
            for (int m = 0; m < 30; m++) apply("R10", 16'($urandom()));
        end

        // R6: sparse rows, near-all-ones inputs to make groups light up.
        for (int n = 0; n < 5; n++) begin
            a = '1;
            for (int t = 0; t < N_TERM; t++) a[t*N_COL + 2*$urandom_range(0, N_IN-1)] = 1'b0;
            load(a, '0);
            for (int m = 0; m < 10; m++) apply("R6", ~16'(1 << $urandom_range(0, N_IN-1)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule